// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit sits between the receive/transmit paths of a serial port and its host-visible status register. It gathers every condition that can interrupt the host: sticky line errors, the receive trigger, a character timeout, free transmit space and changes on the modem handshake inputs. It then reports the single most urgent enabled one as a 3-bit cause code beside an active-low pending flag. The same 32-bit status word carries a modem status byte and a line status byte, so one read tells the host both what happened and why.

The modem handshake inputs are resynchronised and edge-detected here. Every sticky flag (modem deltas, line errors, timeout) is cleared by a status read, but only when that read happens while the matching cause is the one being reported. The four modem control outputs are driven from the control input. A loopback control turns them off and feeds them back internally as the modem inputs.

Top module: `uirq_ident`

## Requirements
- R1: `status_o` is a registered word that reflects the sources as they stood at the previous clock edge. Bit 0 is the pending flag, which is 0 when an interrupt is pending. Bits 3:1 hold the cause code. Bits 7:4 and 31:24 read 0.
- R2: The cause codes are 3 for a line status error, 2 for receive data at trigger, 6 for character timeout, 1 for transmit space and 0 for a modem status change.
- R3: When several causes are active, the order of precedence is line status, then receive data, then timeout, then transmit space, then modem status.
- R4: `ien_i` bit 0 enables both receive data and timeout, bit 1 enables transmit space, bit 2 enables line status and bit 3 enables modem status. A cause whose enable bit is 0 never makes the unit pending.
- R5: When no enabled cause is active, bit 0 reads 1 and the cause code reads 0.
- R6: Status bits 15:8 hold the modem status byte. Bits 11:8 are delta CTS, delta DSR, RI trailing edge and delta DCD. Bits 15:12 are the CTS, DSR, RI and DCD levels. Every modem input passes through a two-stage synchroniser first.
- R7: A delta bit is set by any change of the synchronised CTS, DSR or DCD. For RI it is set only by a 1-to-0 change. All four delta bits are cleared by a read (`stat_rd_i`) taken while the word shows code 0 with pending low. A read at any other time leaves them set.
- R8: Status bits 23:16 hold the line status byte. Bit 16 is the data-ready level, 17 is overrun, 18 is parity, 19 is framing, 20 is break, 21 is the holding-empty level, 22 is the transmitter-empty level and 23 is the receive FIFO error. Bits 17–20 and 23 are sticky and are cleared by a read taken while code 3 is shown.
- R9: A pulse on `rx_timeout_i` sets a sticky timeout flag. A read taken while code 2 or code 6 is shown clears it.
- R10: `mctl_i` bits 0 to 3 drive DTR, RTS, OUT1 and OUT2. When bit 4 (loopback) is set, all four outputs are driven to 0, and the modem inputs are taken as CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2.
- R11: If a sticky flag is set in the same cycle that a read clears it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_i | input | 4 | Per-cause enables |
| mctl_i | input | 5 | DTR, RTS, OUT1, OUT2, loopback |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| ri_i | input | 1 | Ring indicator input, asynchronous |
| dcd_i | input | 1 | Carrier detect input, asynchronous |
| rx_ready_i | input | 1 | At least one received byte held |
| rx_trig_i | input | 1 | Receive fill at or above trigger level |
| rx_timeout_i | input | 1 | Character timeout pulse |
| ovr_err_i | input | 1 | Overrun error pulse |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_i | input | 1 | Break detected pulse |
| fifo_err_i | input | 1 | Receive FIFO error pulse |
| thr_empty_i | input | 1 | Transmit holding store empty |
| tx_idle_i | input | 1 | Transmitter fully empty |
| tx_space_i | input | 1 | Transmit space at or above level |
| stat_rd_i | input | 1 | Host reads the status word this cycle |
| status_o | output | 32 | Packed status word |
| dtr_o | output | 1 | DTR output |
| rts_o | output | 1 | RTS output |
| out1_o | output | 1 | OUT1 output |
| out2_o | output | 1 | OUT2 output |

## Verification
The bench targets the read-clear rule. It reads while a lower cause is shown, and it reads while the unit is idle but delta bits are set. A design that clears on every read would lose modem deltas or line errors that no one has serviced. It drives RI high and then low, which catches a design that flags both RI edges. It stacks simultaneous causes, including a timeout under receive data and an error over everything else, to expose any wrong precedence. It toggles loopback, which must produce deltas from the internal feed while the pins stay quiet.

// File: rtl/uirq_pkg.sv
// Shared types for the serial interrupt identification unit.
package uirq_pkg;
    // Cause codes reported in status bits 3:1
    typedef enum logic [2:0] {
        CAUSE_MDM  = 3'd0,
        CAUSE_TXS  = 3'd1,
        CAUSE_RXD  = 3'd2,
        CAUSE_LINE = 3'd3,
        CAUSE_CTO  = 3'd6
    } cause_e;

    // Enable bit positions in ien_i
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    // Modem control bit positions in mctl_i
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;
    localparam int MC_LOOP = 4;

    // Number of sticky line error flags
    localparam int LINE_ERRS = 5;

    // Modem line set, cts in bit 0 up to dcd in bit 3
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_t;
endpackage

// File: rtl/uirq_sticky.sv
// Sticky flag bank: each bit is set by its pulse and cleared by clr.
// Assumes clr is a single-cycle strobe; a set in the clearing cycle wins.
module uirq_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] flags
);
    // Hold flags until cleared, new events take precedence
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~{W{clr}}) | set;
    end
endmodule

// File: rtl/uirq_mdm_sense.sv
// Modem input sensing: multi-stage synchroniser, edge detection and
// sticky delta capture. Assumes raw inputs are asynchronous levels.
// RI reports only its trailing (1 to 0) edge.
module uirq_mdm_sense import uirq_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  mdm_t raw,
    input  logic clr,
    output mdm_t lvl,
    output mdm_t delta
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [3:0] stage [SYNC_STAGES];
    mdm_t prev;
    mdm_t chg;

    // First synchroniser stage captures the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= raw;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        // Further synchroniser stages
        always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
        end
    end

    assign lvl = stage[LAST];

    // Remember last synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Change detection, RI on falling edge only
    always_comb begin
        chg     = lvl ^ prev;
        chg.ri  = prev.ri & ~lvl.ri;
    end

    uirq_sticky #(.W(4)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (chg),
        .clr   (clr),
        .flags (delta)
    );
endmodule

// File: rtl/uirq_prio.sv
// Priority encoder for interrupt causes after enable masking.
// Order: line, receive data, timeout, transmit space, modem.
module uirq_prio import uirq_pkg::*; (
    input  logic [3:0] ien,
    input  logic       line_any,
    input  logic       rx_trig,
    input  logic       cto,
    input  logic       tx_space,
    input  logic       mdm_any,
    output logic       pend,
    output cause_e     cause
);
    // Pick the highest enabled active cause
    always_comb begin
        pend  = 1'b1;
        cause = CAUSE_MDM;
        if (ien[EN_LINE] && line_any)      cause = CAUSE_LINE;
        else if (ien[EN_RX] && rx_trig)    cause = CAUSE_RXD;
        else if (ien[EN_RX] && cto)        cause = CAUSE_CTO;
        else if (ien[EN_TX] && tx_space)   cause = CAUSE_TXS;
        else if (ien[EN_MDM] && mdm_any)   cause = CAUSE_MDM;
        else                               pend  = 1'b0;
    end
endmodule

// File: rtl/uirq_ident.sv
// Interrupt identification unit top. Packs a registered status word with
// active-low pending flag, cause code, modem and line status bytes.
// Clears sticky flags on a status read only for the cause being shown.
// Assumes stat_rd_i is high for one cycle per host read.
module uirq_ident import uirq_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  ien_i,
    input  logic [4:0]  mctl_i,
    input  logic        cts_i,
    input  logic        dsr_i,
    input  logic        ri_i,
    input  logic        dcd_i,
    input  logic        rx_ready_i,
    input  logic        rx_trig_i,
    input  logic        rx_timeout_i,
    input  logic        ovr_err_i,
    input  logic        par_err_i,
    input  logic        frm_err_i,
    input  logic        brk_i,
    input  logic        fifo_err_i,
    input  logic        thr_empty_i,
    input  logic        tx_idle_i,
    input  logic        tx_space_i,
    input  logic        stat_rd_i,
    output logic [31:0] status_o,
    output logic        dtr_o,
    output logic        rts_o,
    output logic        out1_o,
    output logic        out2_o
);
    logic                 loop;
    mdm_t                 mdm_raw, mdm_lvl, mdm_dlt;
    logic [LINE_ERRS-1:0] err_set, err_q;
    logic                 cto_q;
    logic                 pend;
    cause_e               cause;
    logic [31:0]          status_q;
    logic [2:0]           shown;
    logic                 rd_hit, clr_mdm, clr_line, clr_cto;
    logic [7:0]           msr, lsr;

    assign loop = mctl_i[MC_LOOP];

    // Modem control outputs, silenced in loopback
    assign dtr_o  = mctl_i[MC_DTR]  & ~loop;
    assign rts_o  = mctl_i[MC_RTS]  & ~loop;
    assign out1_o = mctl_i[MC_OUT1] & ~loop;
    assign out2_o = mctl_i[MC_OUT2] & ~loop;

    // Select modem source: pins or internal loopback
    always_comb begin
        if (loop) begin
            mdm_raw.cts = mctl_i[MC_RTS];
            mdm_raw.dsr = mctl_i[MC_DTR];
            mdm_raw.ri  = mctl_i[MC_OUT1];
            mdm_raw.dcd = mctl_i[MC_OUT2];
        end else begin
            mdm_raw.cts = cts_i;
            mdm_raw.dsr = dsr_i;
            mdm_raw.ri  = ri_i;
            mdm_raw.dcd = dcd_i;
        end
    end

    // Read-clear decode against the cause currently shown
    assign shown    = status_q[3:1];
    assign rd_hit   = stat_rd_i & ~status_q[0];
    assign clr_mdm  = rd_hit && (shown == CAUSE_MDM);
    assign clr_line = rd_hit && (shown == CAUSE_LINE);
    assign clr_cto  = rd_hit && ((shown == CAUSE_RXD) || (shown == CAUSE_CTO));

    uirq_mdm_sense #(.SYNC_STAGES(SYNC_STAGES)) u_mdm (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (mdm_raw),
        .clr   (clr_mdm),
        .lvl   (mdm_lvl),
        .delta (mdm_dlt)
    );

    assign err_set = {fifo_err_i, brk_i, frm_err_i, par_err_i, ovr_err_i};

    uirq_sticky #(.W(LINE_ERRS)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (clr_line),
        .flags (err_q)
    );

    uirq_sticky #(.W(1)) u_cto (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rx_timeout_i),
        .clr   (clr_cto),
        .flags (cto_q)
    );

    uirq_prio u_prio (
        .ien      (ien_i),
        .line_any (|err_q),
        .rx_trig  (rx_trig_i),
        .cto      (cto_q),
        .tx_space (tx_space_i),
        .mdm_any  (|mdm_dlt),
        .pend     (pend),
        .cause    (cause)
    );

    // Assemble status bytes
    assign msr = {mdm_lvl, mdm_dlt};
    assign lsr = {err_q[4], tx_idle_i, thr_empty_i, err_q[3:0], rx_ready_i};

    // Register the status word
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 32'h0000_0001;
        else        status_q <= {8'h00, lsr, msr, 4'h0, cause, ~pend};
    end

    assign status_o = status_q;
endmodule

// File: rtl/uirq_ident_chk.sv
// Property checker for uirq_ident, attached by bind.
module uirq_ident_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  ien_i,
    input logic [4:0]  mctl_i,
    input logic        tx_space_i,
    input logic [31:0] status_o,
    input logic        dtr_o,
    input logic        rts_o,
    input logic        out1_o,
    input logic        out2_o
);
    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:4] == 4'h0) && (status_o[31:24] == 8'h00) && !$isunknown(status_o));

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] |-> (status_o[3:1] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}));

    p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> (status_o[3:1] == 3'd0));

    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ien_i[2]) && ((|status_o[20:17]) || status_o[23]))
        |-> (!status_o[0] && status_o[3:1] == 3'd3));

    p_tx_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_space_i && ien_i[1]))
        |-> (!status_o[0] && status_o[3:1] != 3'd0));

    p_mdm_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ien_i[3]) && (|status_o[11:8])) |-> !status_o[0]);

    p_loop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mctl_i[4] |-> !(dtr_o || rts_o || out1_o || out2_o));
endmodule

bind uirq_ident uirq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien_i      (ien_i),
    .mctl_i     (mctl_i),
    .tx_space_i (tx_space_i),
    .status_o   (status_o),
    .dtr_o      (dtr_o),
    .rts_o      (rts_o),
    .out1_o     (out1_o),
    .out2_o     (out2_o)
);

// File: tb/sim_uirq_ident.sv
module sim_uirq_ident;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ien_i = '0;
    logic [4:0] mctl_i = '0;
    logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic rx_ready_i = 0, rx_trig_i = 0, rx_timeout_i = 0;
    logic ovr_err_i = 0, par_err_i = 0, frm_err_i = 0, brk_i = 0, fifo_err_i = 0;
    logic thr_empty_i = 0, tx_idle_i = 0, tx_space_i = 0, stat_rd_i = 0;
    logic [31:0] status_o;
    logic dtr_o, rts_o, out1_o, out2_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [4:0] m_err = '0;   // ovr,par,frm,brk,fifo in bits 0..4
    logic       m_cto = 0;
    logic [3:0] m_dlt = '0;   // cts,dsr,ri,dcd in bits 0..3
    logic [3:0] m_lvl = '0;

    always #5 clk = ~clk;

    uirq_ident u0 (.*);

    function automatic logic [3:0] eff_mdm();
        if (mctl_i[4]) return {mctl_i[3], mctl_i[2], mctl_i[0], mctl_i[1]};
        return {dcd_i, ri_i, dsr_i, cts_i};
    endfunction

    // {code, pending_n}
    function automatic logic [3:0] exp_id();
        if (ien_i[2] && |m_err)      return {3'd3, 1'b0};
        if (ien_i[0] && rx_trig_i)   return {3'd2, 1'b0};
        if (ien_i[0] && m_cto)       return {3'd6, 1'b0};
        if (ien_i[1] && tx_space_i)  return {3'd1, 1'b0};
        if (ien_i[3] && |m_dlt)      return {3'd0, 1'b0};
        return {3'd0, 1'b1};
    endfunction

    function automatic logic [31:0] exp_status();
        logic [7:0] lsr, msr;
        lsr = {m_err[4], tx_idle_i, thr_empty_i, m_err[3:0], rx_ready_i};
        msr = {m_lvl, m_dlt};
        return {8'h00, lsr, msr, 4'h0, exp_id()};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply a modem source change and update delta model
    task automatic mdm_update();
        logic [3:0] nv;
        nv = eff_mdm();
        m_dlt[0] |= nv[0] ^ m_lvl[0];
        m_dlt[1] |= nv[1] ^ m_lvl[1];
        m_dlt[2] |= m_lvl[2] & ~nv[2];
        m_dlt[3] |= nv[3] ^ m_lvl[3];
        m_lvl = nv;
        tick(5);
    endtask

    task automatic pulse_err(input int idx);
        case (idx)
            0: ovr_err_i = 1; 1: par_err_i = 1; 2: frm_err_i = 1;
            3: brk_i = 1; default: fifo_err_i = 1;
        endcase
        m_err[idx] = 1'b1;
        tick(1);
        {ovr_err_i, par_err_i, frm_err_i, brk_i, fifo_err_i} = '0;
        tick(1);
    endtask

    task automatic pulse_cto();
        rx_timeout_i = 1; m_cto = 1;
        tick(1);
        rx_timeout_i = 0;
        tick(1);
    endtask

    task automatic do_read();
        logic [3:0] id;
        id = exp_id();
        stat_rd_i = 1;
        tick(1);
        stat_rd_i = 0;
        if (!id[0]) begin
            if (id[3:1] == 3'd0) m_dlt = '0;
            if (id[3:1] == 3'd3) m_err = '0;
            if (id[3:1] == 3'd2 || id[3:1] == 3'd6) m_cto = 0;
        end
        tick(1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 R5: reset state, idle
        chk("R1 R5 reset", status_o, 32'h0000_0001);

        // R2 R4: transmit space disabled then enabled
        tx_space_i = 1; tick(2);
        chk("R4 tx disabled", status_o, exp_status());
        ien_i = 4'b1111; tick(2);
        chk("R2 tx code", status_o, 32'h0000_0002);

        // R3: receive data beats transmit space
        rx_trig_i = 1; rx_ready_i = 1; tick(2);
        chk("R3 rx over tx", status_o, exp_status());

        // R9: timeout under rx data, then alone
        pulse_cto(); tick(1);
        chk("R3 rx over timeout", status_o, exp_status());
        rx_trig_i = 0; tick(2);
        chk("R9 timeout code", status_o, exp_status());
        do_read();
        chk("R9 timeout cleared", status_o, exp_status());

        // R8 R3: error wins over everything, read clears
        rx_trig_i = 1;
        pulse_err(0); pulse_err(3); tick(1);
        chk("R8 line code and byte", status_o, exp_status());
        do_read();
        chk("R8 line cleared", status_o, exp_status());
        pulse_err(4); tick(1);
        chk("R8 fifo error", status_o, exp_status());
        do_read();

        // R6 R7: modem deltas
        rx_trig_i = 0; tx_space_i = 0;
        cts_i = 1; mdm_update();
        chk("R6 cts delta", status_o, exp_status());
        do_read();
        chk("R7 delta cleared", status_o, exp_status());
        ri_i = 1; mdm_update();
        chk("R7 ri rise no delta", status_o, exp_status());
        ri_i = 0; mdm_update();
        chk("R7 ri fall delta", status_o, exp_status());

        // R7: read while not showing modem cause leaves deltas
        ien_i = 4'b0111; tick(2);
        do_read();
        chk("R7 idle read keeps deltas", status_o, exp_status());
        tx_space_i = 1; tick(2);
        do_read();
        chk("R7 tx read keeps deltas", status_o, exp_status());
        tx_space_i = 0; ien_i = 4'b1111; tick(2);
        do_read();
        chk("R7 modem read clears", status_o, exp_status());

        // R11: error arriving during a clearing read stays set
        pulse_err(1); tick(1);
        stat_rd_i = 1; frm_err_i = 1;
        tick(1);
        stat_rd_i = 0; frm_err_i = 0;
        m_err = 5'b00100;
        tick(1);
        chk("R11 set wins", status_o, exp_status());
        do_read();

        // R10: output drive and loopback
        mctl_i = 5'b01011; tick(1);
        chk("R10 outputs", {28'h0, out2_o, out1_o, rts_o, dtr_o}, 32'h0000_000B);
        mctl_i = 5'b10110; tick(1);
        chk("R10 loop quiet", {28'h0, out2_o, out1_o, rts_o, dtr_o}, 32'h0);
        mdm_update();
        chk("R10 loop levels", status_o, exp_status());
        do_read();
        mctl_i = 5'b00000; mdm_update();
        do_read();
        chk("R10 back from loop", status_o, exp_status());

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            ien_i       = 4'($urandom);
            rx_trig_i   = 1'($urandom);
            rx_ready_i  = 1'($urandom);
            tx_space_i  = 1'($urandom);
            thr_empty_i = 1'($urandom);
            tx_idle_i   = 1'($urandom);
            r = int'($urandom % 8);
            if (r == 0) pulse_err(int'($urandom % 5));
            else if (r == 1) pulse_cto();
            else if (r == 2) begin
                {dcd_i, ri_i, dsr_i, cts_i} = 4'($urandom);
                mdm_update();
            end
            tick(2);
            chk("R3 R4 random", status_o, exp_status());
            if ($urandom % 2 == 0) begin
                do_read();
                chk("R7 R8 R9 random read", status_o, exp_status());
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule